// File: doc/BRIEF.md
# Delayed-Parity Command Error Checker

This block watches a 28-bit command word that is registered on every rising clock edge and checks it against a parity bit that the sender delivers one clock later. Only 22 of the 28 positions take part in the check; the rest carry per-module signals (clock enables, termination controls, chip-selects) and are left out. A static mode input chooses which 22 positions are checked. Valid words have even parity: the count of ones over the 22 checked bits plus the parity bit is even.

The result drives an active-low error flag. A mismatch for a word registered at edge n pulls the flag low at edge n+2. The flag is then stretched: it stays low for at least two cycles, stays low for as long as mismatches keep arriving, and freezes whenever both chip-selects are high (the low-power state). A flag raised just before the low-power state therefore stays low for the whole low-power period and two cycles beyond it. An asynchronous active-low reset forces the flag inactive and clears the pipeline.

Top module: `dpar_err_check`

## Requirements
- R1: A word whose 22 checked bits plus its parity bit hold an even number of ones never drives `err_no` low.
- R2: A word with an odd count drives `err_no` low; the parity bit sampled at edge n+1 belongs to the word sampled at edge n.
- R3: For a mismatching word sampled at edge n, `err_no` is high after edge n+1 and low after edge n+2 (edges n+1 and n+2 not in low-power).
- R4: Once low, `err_no` stays low for at least two cycles: after an isolated mismatch it is low after edges k and k+1 and high after edge k+2.
- R5: Mismatches on consecutive cycles keep `err_no` low throughout; it returns high two non-low-power edges after the last mismatch edge.
- R6: At any edge where `cs0_ni` and `cs1_ni` are both high, `err_no` keeps its value and the stretch count does not advance; a mismatch reaching the flag at such an edge is discarded.
- R7: A flag that went low at the edge just before the low-power state stays low for the whole low-power period and for two more cycles after it.
- R8: With `sel_b_i` = 0 the checked positions (bit 0 = lowest) are bits 0-4, 6, 8-11 and 16-27; with `sel_b_i` = 1 they are bits 0-11, 16-19, 21 and 23-27. Other bits do not affect the result.
- R9: While `rst_ni` is low, `err_no` is high at once, even in the middle of a stretch.
- R10: After reset release the pipeline holds cleared data and parity, so all-zero words with zero parity raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_b_i | input | 1 | Static selection of the checked bit set |
| cmd_i | input | 28 | Command word, sampled every edge |
| cs0_ni | input | 1 | Chip-select 0, active low |
| cs1_ni | input | 1 | Chip-select 1, active low |
| par_i | input | 1 | Parity bit for the word sampled one edge earlier |
| err_no | output | 1 | Parity error flag, active low |

## Verification
The hardest case to reach is a flag that drops exactly on the edge before the low-power state begins, because the mismatching word must be placed two cycles ahead and its parity one cycle ahead of the chip-select change. The stimulus task issues each word together with the parity of the previous one, so a word marked bad is followed by the low-power request a fixed three calls later. A behavioural model built on queues and an edge counter predicts the flag on every cycle in both bit-set modes, including reset asserted mid-stretch.

// File: rtl/dpar_pkg.sv
package dpar_pkg;
  localparam int CMD_W = 28;
  // checked positions per mode
  localparam logic [CMD_W-1:0] SEL_A_MASK = 28'h0FFF0F5F;
  localparam logic [CMD_W-1:0] SEL_B_MASK = 28'h0FAF0FFF;
endpackage

// File: rtl/dpar_pipe.sv
module dpar_pipe
  import dpar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_b_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             par_i,
  output logic             bad_o
);
  logic [CMD_W-1:0] cmd_q, chk;
  logic             odd_q, par_q;

  for (genvar i = 0; i < CMD_W; i++) begin : g_bit
    assign chk[i] = cmd_q[i] & (sel_b_i ? SEL_B_MASK[i] : SEL_A_MASK[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      odd_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      odd_q <= ^chk;   // parity of word from previous edge
      par_q <= par_i;  // its late parity bit
    end
  end

  assign bad_o = odd_q ^ par_q;
endmodule

// File: rtl/dpar_stretch.sv
module dpar_stretch #(
  parameter int MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_i,
  input  logic hold_i,
  output logic err_no
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_LOW - 1);

  logic [CW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b1;
      cnt_q <= '0;
    end else if (!hold_i) begin
      if (bad_i) begin
        err_q <= 1'b0;
        cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign err_no = err_q;

  AST_LP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(err_no)); // R6
  AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_i && !hold_i) |=> !err_no); // R2
  AST_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_no) |-> $past(!bad_i && !hold_i)); // R5

  if (MIN_LOW > 1) begin : g_min
    AST_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_no) |=> !err_no); // R4
  end
endmodule

// File: rtl/dpar_err_check.sv
module dpar_err_check
  import dpar_pkg::*;
#(
  parameter int MIN_LOW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_b_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cs0_ni,
  input  logic             cs1_ni,
  input  logic             par_i,
  output logic             err_no
);
  logic bad, lp_hold;

  assign lp_hold = cs0_ni & cs1_ni;

  dpar_pipe u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_b_i (sel_b_i),
    .cmd_i   (cmd_i),
    .par_i   (par_i),
    .bad_o   (bad)
  );

  dpar_stretch #(.MIN_LOW(MIN_LOW)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bad_i  (bad),
    .hold_i (lp_hold),
    .err_no (err_no)
  );
endmodule

// File: tb/dpar_err_check_tb.sv
`timescale 1ns/1ps
module dpar_err_check_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_b_i = 1'b0;
  logic [27:0] cmd_i = '0;
  logic        cs0_ni = 1'b0;
  logic        cs1_ni = 1'b0;
  logic        par_i = 1'b0;
  logic        err_no;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";
  logic pend = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  dpar_err_check u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  // checked positions, 1-based lists from the requirement (R8)
  function automatic logic [27:0] chk_mask(input logic b);
    logic [27:0] m = '0;
    for (int k = 1; k <= 28; k++) begin
      if (!b) begin
        if (k <= 5 || k == 7 || (k >= 9 && k <= 12) || k >= 17) m[k-1] = 1'b1;
      end else begin
        if (k <= 12 || (k >= 17 && k <= 20) || k == 22 || k >= 24) m[k-1] = 1'b1;
      end
    end
    return m;
  endfunction

  // behavioural reference
  logic [27:0] dq[$];
  logic        pq[$];
  int          since;
  logic        exp_err_n;
  assign exp_err_n = (since >= 2);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq = {28'd0, 28'd0};
      pq = {1'b0};
      since = 1000;
    end else begin
      logic bad;
      dq.push_back(cmd_i);
      pq.push_back(par_i);
      bad = $countones(dq[dq.size()-3] & chk_mask(sel_b_i)) % 2 != pq[pq.size()-2];
      if (!(cs0_ni && cs1_ni)) begin
        if (bad) since = 0;
        else if (since < 1000) since++;
      end
      if (dq.size() > 4) void'(dq.pop_front());
      if (pq.size() > 4) void'(pq.pop_front());
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s err_no actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare, then drive word, parity of previous word, chip-selects
  task automatic cyc(input logic [27:0] w, input logic inj, input logic lp);
    @(negedge clk_i);
    check(cur_req, err_no, exp_err_n);
    cmd_i = w;
    par_i = pend;
    pend = (^(w & chk_mask(sel_b_i))) ^ inj;
    cs0_ni = lp ? 1'b1 : rs[3];
    cs1_ni = lp ? 1'b1 : ~rs[3];
  endtask

  function automatic logic [27:0] nxt();
    rs = rs * 32'd1664525 + 32'd1013904223;
    return rs[31:4];
  endfunction

  task automatic do_reset(input logic b);
    @(negedge clk_i);
    rst_ni = 1'b0;
    sel_b_i = b;
    cmd_i = '0; par_i = 1'b0; pend = 1'b0; cs0_ni = 1'b0; cs1_ni = 1'b0;
    #1 check("R9", err_no, 1'b1);
    repeat (2) @(negedge clk_i);
    check("R9", err_no, 1'b1);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R10: cleared pipeline, zero words
    cur_req = "R10";
    repeat (4) cyc('0, 1'b0, 1'b0);
    // R1: valid words, mode A
    cur_req = "R1";
    repeat (20) cyc(nxt(), 1'b0, 1'b0);
    // R3: latency of a single bad word, explicit sampling
    cur_req = "R3";
    cyc(nxt(), 1'b1, 1'b0);            // word at edge n
    cyc(nxt(), 1'b0, 1'b0);            // parity at edge n+1
    cyc(nxt(), 1'b0, 1'b0);
    check("R3", err_no, 1'b1);         // after edge n+1
    cyc(nxt(), 1'b0, 1'b0);
    check("R3", err_no, 1'b0);         // after edge n+2
    // R4: minimum low time
    cur_req = "R4";
    cyc(nxt(), 1'b0, 1'b0);
    check("R4", err_no, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);
    check("R4", err_no, 1'b1);
    repeat (4) cyc(nxt(), 1'b0, 1'b0);
    // R2: scattered odd words
    cur_req = "R2";
    for (int i = 0; i < 12; i++) cyc(nxt(), (i % 5) == 0, 1'b0);
    repeat (4) cyc(nxt(), 1'b0, 1'b0);
    // R5: run of consecutive errors
    cur_req = "R5";
    repeat (5) cyc(nxt(), 1'b1, 1'b0);
    repeat (6) cyc(nxt(), 1'b0, 1'b0);
    // R6: low-power freezes a high flag and discards errors
    cur_req = "R6";
    cyc(nxt(), 1'b1, 1'b0);
    cyc(nxt(), 1'b1, 1'b1);
    repeat (4) cyc(nxt(), 1'b0, 1'b1);
    repeat (4) cyc(nxt(), 1'b0, 1'b0);
    // R7: flag drops at the edge before low-power
    cur_req = "R7";
    cyc(nxt(), 1'b1, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);            // flag drops at this edge
    repeat (6) cyc(nxt(), 1'b0, 1'b1);
    check("R7", err_no, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);
    check("R7", err_no, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);
    check("R7", err_no, 1'b0);
    cyc(nxt(), 1'b0, 1'b0);
    check("R7", err_no, 1'b1);
    // R9: reset in the middle of a stretch
    cur_req = "R9";
    cyc(nxt(), 1'b1, 1'b0);
    repeat (3) cyc(nxt(), 1'b0, 1'b0);
    check("R9", err_no, 1'b0);
    do_reset(1'b1);
    // R8: mode B; excluded bits toggled freely
    cur_req = "R8";
    repeat (2) cyc('0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(nxt() & chk_mask(1'b1) | (28'h0500000 & {28{i[0]}}) | 28'h0003000, 1'b0, 1'b0);
    // bit 5 checked in mode B only: odd word must flag
    cyc(28'h0000020, 1'b1, 1'b0);
    repeat (6) cyc(nxt(), 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) cyc(nxt(), (i % 4) == 1, (i % 7) == 3);
    repeat (6) cyc(nxt(), 1'b0, 1'b0);
    // R8: mode A, bits 5, 7, 12-15 excluded
    do_reset(1'b0);
    repeat (2) cyc('0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(28'h000F0A0 ^ (nxt() & chk_mask(1'b0)), 1'b0, 1'b0);
    cyc(28'h0000040, 1'b1, 1'b0);
    repeat (6) cyc(nxt(), 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule